// File: doc/BRIEF.md
# FEC Codeword Sync-Burst Aligner

This block recovers codeword boundaries in a stream of forward-error-corrected codewords. It receives one 10-bit parallel word per clock from a serial-to-parallel front end whose word phase is arbitrary. Between every two codewords the transmitter places a fixed 10-bit sync burst that holds five ones and five zeros. Apart from that burst the stream is scrambled. The aligner needs no handshake with the transmitter. It scans all ten bit offsets of a two-word window every cycle for the burst. When it finds the burst, it waits one full burst-plus-codeword period and checks that the burst comes back at the same offset.

After enough confirmations the aligner asserts a lock flag. It then delivers words that are re-framed to the burst boundary, plus a strobe on the first word of every codeword. While locked it keeps the period count running through missed bursts. It gives up only after a run of misses, and then returns to the search over all offsets. The burst value and the codeword length are parameters. The defaults give a 5440-bit codeword and therefore a 545-word period.

Top module: `sync_burst_aligner`

## Requirements
- R1: While rst_ni is low, lock_o and sof_o are 0 and data_o is zero. Asserting rst_ni while locked clears lock_o and sof_o at once, without waiting for a clock edge.
- R2: The stream is serial with data_i[9] earliest in time. The burst is found whatever its bit offset (0 to 9) inside the incoming words.
- R3: With P = (CW_BITS+10)/10 words per period, lock_o rises right after the clock edge that sees the third consecutive confirmation. Each confirmation is the burst seen at the found offset exactly P words after the previous sighting. With P = 7 and the first burst starting in word 0, this is the edge that samples word 22.
- R4: If the burst is absent at its expected slot before lock is reached, the search restarts over all ten offsets and a later burst becomes a new first sighting.
- R5: Once locked, up to three consecutive missing bursts leave lock_o high, and the period count keeps running.
- R6: The fourth consecutive missing burst clears lock_o right after the clock edge of that slot. The search then resumes.
- R7: While locked, sof_o pulses for one cycle every P cycles, on the word that follows the burst slot. The first pulse comes one cycle after lock_o rises.
- R8: data_o carries the 10 stream bits that start at the locked offset, so each word lines up with codeword boundaries. It appears two cycles after the word that completes it enters data_i.
- R9: The BURST parameter must hold exactly five ones and five zeros, and CW_BITS must be a multiple of 10. Any other value stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 10 | Raw word from the deserializer, bit 9 earliest |
| data_o | output | 10 | Word re-framed to the burst boundary |
| sof_o | output | 1 | First word of a codeword |
| lock_o | output | 1 | Burst position confirmed |

## Verification
The bench builds the aligner with a 60-bit codeword, which gives a 7-word period. This makes a lock in about 22 words and a loss of lock a few dozen words later. The burst is 1111100000. The payload words never hold a run of five ones, so the only place the burst pattern occurs is the real burst. The bench places the stream at bit shifts 0, 3, 5, 6, 9 and 2 and removes chosen bursts. This drives the confirm-fail restart, the flywheel through three misses and the drop on the fourth miss at exactly predictable cycles.

// File: rtl/sync_burst_pkg.sv
package sync_burst_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } align_state_e;
endpackage

// File: rtl/burst_window_match.sv
module burst_window_match #(
  parameter int          W     = 10,
  parameter logic [W-1:0] BURST = 10'b1111100000
) (
  input  logic [W-1:0]        prev_i,
  input  logic [W-1:0]        cur_i,
  output logic [W-1:0][W-1:0] cand_o,
  output logic [W-1:0]        match_o
);
  logic [2*W-1:0] win;
  assign win = {prev_i, cur_i};

  // candidate k starts k bits into the older word
  for (genvar k = 0; k < W; k++) begin : g_off
    assign cand_o[k]  = win[2*W-1-k -: W];
    assign match_o[k] = (win[2*W-1-k -: W] == BURST);
  end
endmodule

// File: rtl/first_hit_enc.sv
module first_hit_enc #(
  parameter int W    = 10,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     hit_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (hit_i[k]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/burst_lock_fsm.sv
module burst_lock_fsm
  import sync_burst_pkg::*;
#(
  parameter int W           = 10,
  parameter int PERIOD      = 545,
  parameter int LOCK_HITS   = 3,
  parameter int DROP_MISSES = 4,
  localparam int IDX_W = $clog2(W),
  localparam int CNT_W = $clog2(PERIOD + 1),
  localparam int HIT_W = $clog2(LOCK_HITS + 1),
  localparam int MIS_W = $clog2(DROP_MISSES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     match_i,
  input  logic             found_i,
  input  logic [IDX_W-1:0] found_idx_i,
  output logic [IDX_W-1:0] off_o,
  output logic             lock_o,
  output logic             sof_o
);
  align_state_e     state_q;
  logic [IDX_W-1:0] off_q;
  logic [CNT_W-1:0] cnt_q;
  logic [HIT_W-1:0] hits_q;
  logic [MIS_W-1:0] miss_q;
  logic             sof_q;
  logic             slot, hit;

  assign slot = (cnt_q == CNT_W'(PERIOD));
  assign hit  = match_i[off_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      off_q   <= '0;
      cnt_q   <= '0;
      hits_q  <= '0;
      miss_q  <= '0;
      sof_q   <= 1'b0;
    end else begin
      sof_q <= (state_q == ST_LOCKED) && (cnt_q == CNT_W'(1));
      if (state_q != ST_HUNT) cnt_q <= slot ? CNT_W'(1) : cnt_q + CNT_W'(1);
      unique case (state_q)
        ST_HUNT: if (found_i) begin
          off_q   <= found_idx_i;
          cnt_q   <= CNT_W'(1);
          hits_q  <= '0;
          state_q <= ST_VERIFY;
        end
        ST_VERIFY: if (slot) begin
          if (!hit) state_q <= ST_HUNT;
          else if (hits_q == HIT_W'(LOCK_HITS - 1)) begin
            state_q <= ST_LOCKED;
            miss_q  <= '0;
          end else hits_q <= hits_q + HIT_W'(1);
        end
        ST_LOCKED: if (slot) begin
          if (hit) miss_q <= '0;
          else if (miss_q == MIS_W'(DROP_MISSES - 1)) begin
            miss_q  <= '0;
            state_q <= ST_HUNT;
          end else miss_q <= miss_q + MIS_W'(1);
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  assign off_o  = off_q;
  assign lock_o = (state_q == ST_LOCKED);
  assign sof_o  = sof_q;
endmodule

// File: rtl/sync_burst_aligner.sv
module sync_burst_aligner #(
  parameter logic [9:0] BURST       = 10'b1111100000,
  parameter int         CW_BITS     = 5440,
  parameter int         LOCK_HITS   = 3,
  parameter int         DROP_MISSES = 4,
  localparam int W      = 10,
  localparam int PERIOD = (CW_BITS + W) / W,
  localparam int IDX_W  = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o,
  output logic         sof_o,
  output logic         lock_o
);
  if ($countones(BURST) != W / 2) begin : g_bad_burst
    $error("sync_burst_aligner: BURST must hold five ones and five zeros");
  end
  if (CW_BITS % W != 0) begin : g_bad_len
    $error("sync_burst_aligner: CW_BITS must be a multiple of the word width");
  end

  logic [W-1:0]        prev_q, data_q;
  logic [W-1:0][W-1:0] cand;
  logic [W-1:0]        match;
  logic                found;
  logic [IDX_W-1:0]    found_idx, off;

  burst_window_match #(.W(W), .BURST(BURST)) i_match (
    .prev_i (prev_q),
    .cur_i  (data_i),
    .cand_o (cand),
    .match_o(match)
  );

  first_hit_enc #(.W(W)) i_enc (
    .hit_i  (match),
    .found_o(found),
    .idx_o  (found_idx)
  );

  burst_lock_fsm #(
    .W(W), .PERIOD(PERIOD), .LOCK_HITS(LOCK_HITS), .DROP_MISSES(DROP_MISSES)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .match_i    (match),
    .found_i    (found),
    .found_idx_i(found_idx),
    .off_o      (off),
    .lock_o     (lock_o),
    .sof_o      (sof_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      data_q <= '0;
    end else begin
      prev_q <= data_i;
      data_q <= cand[off];
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/sync_burst_aligner_chk.sv
module sync_burst_aligner_chk #(
  parameter logic [9:0] BURST  = 10'b1111100000,
  parameter int         PERIOD = 545,
  localparam int GAP_W = $clog2(PERIOD + 2)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [9:0] data_o,
  input logic       sof_o,
  input logic       lock_o
);
  logic [GAP_W-1:0] gap_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (sof_o) gap_q <= GAP_W'(1);
      else if (gap_q != GAP_W'(PERIOD + 1)) gap_q <= gap_q + GAP_W'(1);
      if (!lock_o) armed_q <= 1'b0;
      else if (sof_o) armed_q <= 1'b1;
    end
  end

  AST_SOF_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> lock_o); // R7
  AST_FIRST_SOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |=> sof_o); // R7
  AST_LOCK_ON_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> data_o == BURST); // R3
  AST_SOF_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_o && armed_q) |-> gap_q == GAP_W'(PERIOD)); // R7
  AST_DROP_AT_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lock_o) && armed_q) |-> gap_q == GAP_W'(PERIOD - 1)); // R6
endmodule

bind sync_burst_aligner sync_burst_aligner_chk #(.BURST(BURST), .PERIOD(PERIOD)) i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .data_o(data_o),
  .sof_o (sof_o),
  .lock_o(lock_o)
);

// File: tb/test_sync_burst_aligner.sv
module test_sync_burst_aligner;
  localparam logic [9:0] BURST = 10'b1111100000;
  localparam int CW_BITS = 60;
  localparam int P       = 7;
  localparam int NPER    = 16;
  localparam int NW      = P * NPER + 2;
  localparam int NBITS   = NW * 10;
  localparam int NCASE   = 6;
  // shift, burst mask, expected rise edge, expected fall edge (-1 none), rise tag is R4
  localparam int C_SHIFT[NCASE] = '{0, 3, 9, 5, 0, 6};
  localparam int C_MASK [NCASE] = '{32'h00FF, 32'h00FF, 32'h00FF, 32'hFE3F, 32'hFFFD, 32'h000F};
  localparam int C_RISE [NCASE] = '{22, 22, 22, 22, 36, 22};
  localparam int C_FALL [NCASE] = '{78, 78, 78, -1, -1, 50};
  localparam bit C_R4   [NCASE] = '{0, 0, 0, 0, 1, 0};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] data_i = '0;
  logic [9:0] data_o;
  logic       sof_o, lock_o;
  int checks = 0, failures = 0;
  bit done = 0;
  logic strm [NBITS];

  always #4 clk_i = ~clk_i;

  sync_burst_aligner #(.BURST(BURST), .CW_BITS(CW_BITS)) i_sync_burst_aligner (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i),
    .data_o(data_o), .sof_o(sof_o), .lock_o(lock_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] pay(input int j, input int m);
    return {6'b0, 4'(j + m)};
  endfunction

  function automatic logic [9:0] word_at(input int i);
    logic [9:0] w;
    for (int b = 0; b < 10; b++) w[9-b] = (i < NW) ? strm[10*i+b] : 1'b0;
    return w;
  endfunction

  task automatic build(input int s, input int mask);
    for (int b = 0; b < NBITS; b++) strm[b] = 1'b0;
    for (int j = 0; j < NPER; j++) begin
      int base = s + 10 * P * j;
      if (mask[j]) for (int b = 0; b < 10; b++) strm[base+b] = BURST[9-b];
      for (int m = 0; m < P - 1; m++) begin
        logic [9:0] v = pay(j, m);
        for (int b = 0; b < 10; b++) strm[base+10+10*m+b] = v[9-b];
      end
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    data_i = '0;
    repeat (3) @(negedge clk_i);
    chk(lock_o == 0 && sof_o == 0 && data_o == 0, "R1 reset outputs",
        {lock_o, sof_o, data_o}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic run_case(input int s, input int mask, input int exp_rise,
                          input int exp_fall, input bit r4, input int abort_at);
    int rise = -1, fall = -1, pj = 0, pm = 0;
    build(s, mask);
    do_reset();
    data_i = word_at(0);
    for (int i = 0; i < NW; i++) begin
      @(negedge clk_i);
      if (lock_o && rise < 0) rise = i;
      if (!lock_o && rise >= 0 && fall < 0) fall = i;
      if (rise >= 0 && i == rise + 1) chk(sof_o == 1, "R7 first sof after lock", sof_o, 1);
      if (sof_o) begin
        chk(i >= 2 && (i - 2) % P == 0, "R7 sof position", i, ((i - 2) / P) * P + 2);
        pj = (i - 2) / P;
        chk(data_o == pay(pj, 0), "R8 first codeword word", data_o, pay(pj, 0));
        pm = 1;
      end else if (lock_o && pm > 0 && pm < P - 1) begin
        chk(data_o == pay(pj, pm), "R8 aligned word", data_o, pay(pj, pm));
        pm++;
      end else pm = 0;
      if (i == abort_at) begin
        rst_ni = 1'b0;
        #1;
        chk(lock_o == 0 && sof_o == 0, "R1 async reset clears lock", {lock_o, sof_o}, 0);
        break;
      end
      data_i = word_at(i + 1);
    end
    if (abort_at < 0) begin
      if (r4) chk(rise == exp_rise, "R4 restart then lock edge", rise, exp_rise);
      else chk(rise == exp_rise, "R3 R2 lock edge", rise, exp_rise);
      if (exp_fall < 0) chk(fall == -1, "R5 lock held through misses", fall, -1);
      else chk(fall == exp_fall, "R6 drop edge", fall, exp_fall);
    end
  endtask

  initial begin
    chk($countones(BURST) == 5, "R9 burst balance", $countones(BURST), 5);
    for (int c = 0; c < NCASE; c++)
      run_case(C_SHIFT[c], C_MASK[c], C_RISE[c], C_FALL[c], C_R4[c], -1);
    // directed: reset while locked, burst at shift 2
    run_case(2, 32'hFFFF, 22, -1, 0, 40);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule